// File: doc/BRIEF.md
# Credit-Based Transmit Queue Shaper

This block picks which of four egress queues may send next on a byte-per-cycle link and holds that choice for the whole frame. Queues 0 and 1 carry reserved streams (class A and class B). Each has its own credit account, which grows at a configured idle slope and shrinks while its frames go out. Queues 2 and 3 carry prioritised and best-effort traffic with no shaping. A single shaping switch turns credit gating on for the whole block. A per-class mode bit picks shaped or plain priority handling for that class. An optional stall keeps the unshaped queues off the link while any shaped class has data waiting, even if that class cannot send yet.

Each cycle the upstream logic presents a not-empty flag and a head-of-queue frame length for every queue. When the link is idle, the block grants the highest-ranked eligible queue, with queue 0 ranked highest. It then reports that queue as busy for as many cycles as the frame has bytes, and re-arbitrates after one idle cycle. Credit values are exposed in offset-binary form, where 0x80000000 means zero credit. The same form is used for the high-credit limit that software writes.

Top module: `cbs_tx_shaper`

## Requirements
- R1: After reset no queue is granted (`tx_active` = 0) and both credit outputs read 0x80000000.
- R2: Among eligible queues the grant goes to the lowest index (0 before 1 before 2 before 3); with `shaper_en` = 0 every queue with data and a legal length is eligible.
- R3: A grant keeps `tx_active` high and `tx_queue` unchanged for exactly as many cycles as the frame length sampled at grant, followed by at least one idle cycle before the next grant.
- R4: A queue whose frame length is below 64 or above 1522 bytes is never granted; 64 and 1522 are accepted.
- R5: A shaped class with data that is not sending gains its idle slope (control word bits 15:0) each cycle, saturating at its high-credit limit (offset-binary, 0x80000000 = zero).
- R6: A shaped class that is sending changes its credit each cycle by idle slope minus 256 (one byte of link time is 256 credit units), still capped at the limit.
- R7: A shaped class whose credit is below zero is not granted.
- R8: A shaped class with no data resets a positive credit to zero, and raises a negative credit by its idle slope per cycle, no higher than zero.
- R9: With `stall_sp_en` and `shaper_en` set, queues 2 and 3 are not granted while a shaped class has data with a legal length.
- R10: A class is shaped only when `shaper_en` = 1 and bit 31 of its control word is 1; an unshaped class holds zero credit and competes as a plain priority queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one link byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| shaper_en | input | 1 | Global credit-shaping enable |
| stall_sp_en | input | 1 | Hold queues 2/3 while a shaped class has data |
| sr_ctrl_a | input | 32 | Class A control: bit 31 shaped mode, bits 15:0 idle slope |
| sr_ctrl_b | input | 32 | Class B control, same layout |
| sr_hicred_a | input | 32 | Class A credit ceiling, offset-binary |
| sr_hicred_b | input | 32 | Class B credit ceiling, offset-binary |
| q_pend | input | 4 | Per-queue not-empty flags, bit i = queue i |
| q_len_0 | input | 11 | Head frame length of queue 0 in bytes |
| q_len_1 | input | 11 | Head frame length of queue 1 in bytes |
| q_len_2 | input | 11 | Head frame length of queue 2 in bytes |
| q_len_3 | input | 11 | Head frame length of queue 3 in bytes |
| tx_active | output | 1 | A frame is on the link this cycle |
| tx_queue | output | 2 | Queue owning the link |
| credit_a | output | 32 | Class A credit, offset-binary |
| credit_b | output | 32 | Class B credit, offset-binary |

## Verification
A corrupted credit account shows up on the credit ports one cycle after the faulty update. It also moves the instant of the next class grant by a whole number of cycles, because recovery from a negative balance runs at exactly the idle slope. A bad frame counter shows as a wrong busy length, or as `tx_queue` changing mid-frame, within the first frame. A wrong eligibility or stall decision shows at the next arbitration edge as the wrong queue on `tx_queue`, or as a grant that should not happen.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int CRED_W    = 32;
    localparam int SLOPE_W   = 16;
    localparam int LEN_W     = 11;
    localparam int LINK_UNIT = 256;
    localparam int FRAME_MIN = 64;
    localparam int FRAME_MAX = 1522;
    localparam int NUM_Q     = 4;
    localparam int NUM_SR    = 2;

    typedef enum logic [1:0] {
        QID_CLASS_A = 2'd0,
        QID_CLASS_B = 2'd1,
        QID_PRIO    = 2'd2,
        QID_BEST    = 2'd3
    } qid_e;

    typedef struct packed {
        logic active;
        qid_e owner;
    } link_state_t;

    function automatic logic frame_len_legal(input logic [LEN_W-1:0] len);
        return (int'(len) >= FRAME_MIN) && (int'(len) <= FRAME_MAX);
    endfunction
endpackage

// File: rtl/cbs_credit_acct.sv
module cbs_credit_acct #(
    parameter int CRED_W    = cbs_pkg::CRED_W,
    parameter int SLOPE_W   = cbs_pkg::SLOPE_W,
    parameter int LINK_UNIT = cbs_pkg::LINK_UNIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shaped,
    input  logic                     has_data,
    input  logic                     sending,
    input  logic [SLOPE_W-1:0]       idle_slope,
    input  logic signed [CRED_W-1:0] ceiling,
    output logic signed [CRED_W-1:0] credit
);
    localparam int EW = CRED_W + 2;
    localparam logic signed [EW-1:0] LINK_X = EW'(LINK_UNIT);
    localparam logic signed [EW-1:0] FLOOR_X = -(EW'(1) <<< (CRED_W - 1));

    logic signed [EW-1:0] cur_x, slope_x, ceil_x, sum_x, cap_x, nxt_x;

    always_comb begin
        cur_x   = EW'(credit);
        slope_x = $signed({{(EW-SLOPE_W){1'b0}}, idle_slope});
        ceil_x  = EW'(ceiling);
        sum_x   = cur_x + slope_x;
        cap_x   = ceil_x;
        if (!shaped) begin
            sum_x = '0;
            cap_x = '0;
        end else if (sending) begin
            sum_x = cur_x + slope_x - LINK_X;
        end else if (!has_data) begin
            cap_x = '0;
            if (cur_x > 0) sum_x = '0;
        end
        nxt_x = (sum_x > cap_x) ? cap_x : sum_x;
        if (nxt_x < FLOOR_X) nxt_x = FLOOR_X;
    end

    always_ff @(posedge clk) begin
        if (rst) credit <= '0;
        else     credit <= nxt_x[CRED_W-1:0];
    end
endmodule

// File: rtl/cbs_arbiter.sv
module cbs_arbiter #(
    parameter int LEN_W = cbs_pkg::LEN_W,
    parameter int NQ    = cbs_pkg::NUM_Q
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NQ-1:0]             eligible,
    input  logic [NQ-1:0]             held,
    input  logic [NQ-1:0][LEN_W-1:0]  lens,
    output cbs_pkg::link_state_t      link,
    output logic [LEN_W-1:0]          left
);
    import cbs_pkg::*;

    logic [NQ-1:0] cand;
    logic          any_cand;
    qid_e          pick;

    always_comb begin
        cand     = eligible & ~held;
        any_cand = |cand;
        pick     = QID_CLASS_A;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (cand[i]) pick = qid_e'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link.active <= 1'b0;
            link.owner  <= QID_CLASS_A;
            left        <= '0;
        end else if (link.active) begin
            left <= left - 1'b1;
            if (left == LEN_W'(1)) link.active <= 1'b0;
        end else if (any_cand) begin
            link.active <= 1'b1;
            link.owner  <= pick;
            left        <= lens[pick];
        end
    end
endmodule

// File: rtl/cbs_tx_shaper.sv
module cbs_tx_shaper #(
    parameter int CRED_W    = cbs_pkg::CRED_W,
    parameter int SLOPE_W   = cbs_pkg::SLOPE_W,
    parameter int LEN_W     = cbs_pkg::LEN_W,
    parameter int LINK_UNIT = cbs_pkg::LINK_UNIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shaper_en,
    input  logic              stall_sp_en,
    input  logic [CRED_W-1:0] sr_ctrl_a,
    input  logic [CRED_W-1:0] sr_ctrl_b,
    input  logic [CRED_W-1:0] sr_hicred_a,
    input  logic [CRED_W-1:0] sr_hicred_b,
    input  logic [3:0]        q_pend,
    input  logic [LEN_W-1:0]  q_len_0,
    input  logic [LEN_W-1:0]  q_len_1,
    input  logic [LEN_W-1:0]  q_len_2,
    input  logic [LEN_W-1:0]  q_len_3,
    output logic              tx_active,
    output logic [1:0]        tx_queue,
    output logic [CRED_W-1:0] credit_a,
    output logic [CRED_W-1:0] credit_b
);
    import cbs_pkg::*;

    localparam int NQ  = NUM_Q;
    localparam int NSR = NUM_SR;
    localparam logic [CRED_W-1:0] ZERO_PT = {1'b1, {(CRED_W-1){1'b0}}};

    logic [NQ-1:0][LEN_W-1:0]  lens;
    logic [NQ-1:0]             len_good, eligible, held;
    logic [NSR-1:0]            shaped, sr_waiting;
    logic [CRED_W-1:0]         ctrl_w  [NSR];
    logic [CRED_W-1:0]         ceil_w  [NSR];
    logic signed [CRED_W-1:0]  cred_s  [NSR];
    link_state_t               link;
    logic [LEN_W-1:0]          frame_left;

    assign lens      = {q_len_3, q_len_2, q_len_1, q_len_0};
    assign ctrl_w[0] = sr_ctrl_a;
    assign ctrl_w[1] = sr_ctrl_b;
    assign ceil_w[0] = sr_hicred_a;
    assign ceil_w[1] = sr_hicred_b;

    for (genvar g = 0; g < NQ; g++) begin : g_len
        assign len_good[g] = frame_len_legal(lens[g]);
    end

    for (genvar g = 0; g < NSR; g++) begin : g_sr
        logic signed [CRED_W-1:0] ceiling;
        assign shaped[g]  = shaper_en & ctrl_w[g][CRED_W-1];
        assign ceiling    = $signed(ceil_w[g] ^ ZERO_PT);
        assign sr_waiting[g] = shaped[g] & q_pend[g] & len_good[g];
        assign eligible[g] = q_pend[g] & len_good[g] &
                             (~shaped[g] | ~cred_s[g][CRED_W-1]);
        assign held[g]    = 1'b0;

        cbs_credit_acct #(
            .CRED_W(CRED_W), .SLOPE_W(SLOPE_W), .LINK_UNIT(LINK_UNIT)
        ) u_acct (
            .clk        (clk),
            .rst        (rst),
            .shaped     (shaped[g]),
            .has_data   (q_pend[g]),
            .sending    (link.active && (int'(link.owner) == g)),
            .idle_slope (ctrl_w[g][SLOPE_W-1:0]),
            .ceiling    (ceiling),
            .credit     (cred_s[g])
        );
    end

    for (genvar g = NSR; g < NQ; g++) begin : g_sp
        assign eligible[g] = q_pend[g] & len_good[g];
        assign held[g]     = stall_sp_en & shaper_en & (|sr_waiting);
    end

    cbs_arbiter #(.LEN_W(LEN_W), .NQ(NQ)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .eligible (eligible),
        .held     (held),
        .lens     (lens),
        .link     (link),
        .left     (frame_left)
    );

    assign tx_active = link.active;
    assign tx_queue  = link.owner;
    assign credit_a  = cred_s[0] ^ ZERO_PT;
    assign credit_b  = cred_s[1] ^ ZERO_PT;
endmodule

// File: rtl/cbs_tx_shaper_chk.sv
module cbs_tx_shaper_chk #(
    parameter int CRED_W = cbs_pkg::CRED_W,
    parameter int LEN_W  = cbs_pkg::LEN_W
) (
    input logic              clk,
    input logic              rst,
    input logic              shaper_en,
    input logic              stall_sp_en,
    input logic [CRED_W-1:0] sr_ctrl_a,
    input logic [CRED_W-1:0] sr_hicred_a,
    input logic [3:0]        q_pend,
    input logic [LEN_W-1:0]  q_len_0,
    input logic              tx_active,
    input logic [1:0]        tx_queue,
    input logic [CRED_W-1:0] credit_a,
    input logic [LEN_W-1:0]  frame_left
);
    localparam logic [CRED_W-1:0] ZERO_PT = {1'b1, {(CRED_W-1){1'b0}}};

    logic shaped_a, a_negative, a_legal;
    assign shaped_a   = shaper_en & sr_ctrl_a[CRED_W-1];
    assign a_negative = ~credit_a[CRED_W-1];
    assign a_legal    = cbs_pkg::frame_len_legal(q_len_0);

    p_hold_queue_r3: assert property (@(posedge clk) disable iff (rst)
        tx_active |=> (!tx_active || $stable(tx_queue)));

    p_frame_end_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_active && frame_left == LEN_W'(1)) |=> !tx_active);

    p_bad_len_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && q_pend == 4'b0001 && !a_legal) |=> !tx_active);

    p_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        shaped_a |=> (credit_a <= $past(sr_hicred_a) || credit_a <= ZERO_PT));

    p_neg_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && shaped_a && a_negative) |=> !(tx_active && tx_queue == 2'd0));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && stall_sp_en && shaped_a && q_pend[0] && a_legal)
        |=> !(tx_active && tx_queue[1]));

    p_unshaped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !shaped_a |=> credit_a == ZERO_PT);
endmodule

bind cbs_tx_shaper cbs_tx_shaper_chk #(.CRED_W(CRED_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .shaper_en   (shaper_en),
    .stall_sp_en (stall_sp_en),
    .sr_ctrl_a   (sr_ctrl_a),
    .sr_hicred_a (sr_hicred_a),
    .q_pend      (q_pend),
    .q_len_0     (q_len_0),
    .tx_active   (tx_active),
    .tx_queue    (tx_queue),
    .credit_a    (credit_a),
    .frame_left  (frame_left)
);

// File: tb/sim_cbs_tx_shaper.sv
module sim_cbs_tx_shaper;
    localparam int CLK_P = 10;
    localparam logic [31:0] ZP = 32'h8000_0000;
    localparam logic [31:0] MODE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        shaper_en, stall_sp_en;
    logic [31:0] sr_ctrl_a, sr_ctrl_b, sr_hicred_a, sr_hicred_b;
    logic [3:0]  q_pend;
    logic [10:0] q_len_0, q_len_1, q_len_2, q_len_3;
    logic        tx_active;
    logic [1:0]  tx_queue;
    logic [31:0] credit_a, credit_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cbs_tx_shaper u0 (
        .clk(clk), .rst(rst), .shaper_en(shaper_en), .stall_sp_en(stall_sp_en),
        .sr_ctrl_a(sr_ctrl_a), .sr_ctrl_b(sr_ctrl_b),
        .sr_hicred_a(sr_hicred_a), .sr_hicred_b(sr_hicred_b),
        .q_pend(q_pend), .q_len_0(q_len_0), .q_len_1(q_len_1),
        .q_len_2(q_len_2), .q_len_3(q_len_3),
        .tx_active(tx_active), .tx_queue(tx_queue),
        .credit_a(credit_a), .credit_b(credit_b)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; shaper_en = 1'b0; stall_sp_en = 1'b0;
        sr_ctrl_a = '0; sr_ctrl_b = '0; sr_hicred_a = ZP; sr_hicred_b = ZP;
        q_pend = '0; q_len_0 = 11'd64; q_len_1 = 11'd64; q_len_2 = 11'd64; q_len_3 = 11'd64;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // counts negedges until tx_active is seen high
    task automatic wait_active(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tx_active && n < 5000);
    endtask

    // called at the first negedge with tx_active high; returns at first idle negedge
    task automatic measure(input logic [1:0] exp_q, input int exp_len, input string tag);
        int cnt = 1;
        bit steady = 1'b1;
        logic [1:0] q0 = tx_queue;
        check(q0 == exp_q, {tag, " queue"}, 32'(q0), 32'(exp_q));
        forever begin
            @(negedge clk);
            if (!tx_active) break;
            cnt++;
            if (tx_queue != q0) steady = 1'b0;
        end
        check(cnt == exp_len, {tag, " length R3"}, 32'(cnt), 32'(exp_len));
        check(steady, {tag, " queue steady R3"}, 32'(steady), 32'd1);
    endtask

    task automatic grant_from(input logic [3:0] pend, input logic [1:0] exp_q, input string tag);
        int n;
        q_pend = pend;
        wait_active(n);
        check(n == 1, {tag, " grant delay"}, 32'(n), 32'd1);
        measure(exp_q, 64, tag);
        q_pend = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check(tx_active == 1'b0, "R1 idle after reset", 32'(tx_active), 32'd0);
        check(credit_a == ZP, "R1 credit_a zero", credit_a, ZP);
        check(credit_b == ZP, "R1 credit_b zero", credit_b, ZP);
    endtask

    task automatic t_strict();
        do_reset();
        sr_ctrl_a = MODE | 32'd64;
        grant_from(4'b1111, 2'd0, "R2 all pending");
        grant_from(4'b1110, 2'd1, "R2 q1 over q2");
        grant_from(4'b1100, 2'd2, "R2 q2 over q3");
        grant_from(4'b1000, 2'd3, "R2 q3 alone");
        check(credit_a == ZP, "R10 shaping off holds zero", credit_a, ZP);
    endtask

    task automatic t_lengths();
        int n;
        bit quiet;
        do_reset();
        q_len_0 = 11'd63; q_pend = 4'b0001;
        quiet = 1'b1;
        repeat (10) begin @(negedge clk); if (tx_active) quiet = 1'b0; end
        check(quiet, "R4 length 63 ignored", 32'(quiet), 32'd1);
        q_len_0 = 11'd1523;
        repeat (10) begin @(negedge clk); if (tx_active) quiet = 1'b0; end
        check(quiet, "R4 length 1523 ignored", 32'(quiet), 32'd1);
        q_len_1 = 11'd1522; q_pend = 4'b0011;
        wait_active(n);
        measure(2'd1, 1522, "R4 max length on q1");
        q_pend = '0; q_len_0 = 11'd64;
        grant_from(4'b0001, 2'd0, "R4 min length on q0");
    endtask

    task automatic t_credit();
        int n;
        do_reset();
        shaper_en = 1'b1; sr_ctrl_a = MODE | 32'd64; sr_hicred_a = ZP + 32'd1000;
        q_pend = 4'b0001;
        wait_active(n);
        check(n == 1, "R7 zero credit eligible", 32'(n), 32'd1);
        measure(2'd0, 64, "R6 class A frame");
        check(credit_a == 32'h7FFF_D040, "R6 credit after send", credit_a, 32'h7FFF_D040);
        @(negedge clk);
        check(credit_a == 32'h7FFF_D080, "R5 waiting gain", credit_a, 32'h7FFF_D080);
        check(!tx_active, "R7 negative not granted", 32'(tx_active), 32'd0);
        wait_active(n);
        check(n == 191, "R7 recovery time", 32'(n), 32'd191);
        measure(2'd0, 64, "R7 second frame");
        q_pend = '0;
        @(negedge clk);
        check(credit_a == 32'h7FFF_D080, "R8 empty recovers", credit_a, 32'h7FFF_D080);
    endtask

    task automatic t_cap();
        int n;
        do_reset();
        shaper_en = 1'b1; sr_ctrl_a = MODE | 32'd64; sr_hicred_a = ZP + 32'd100;
        q_len_2 = 11'd200; q_pend = 4'b0100;
        wait_active(n);
        check(tx_queue == 2'd2, "R2 q2 alone", 32'(tx_queue), 32'd2);
        q_pend = 4'b0101;
        @(negedge clk);
        check(credit_a == ZP + 32'd64, "R5 gain one step", credit_a, ZP + 32'd64);
        @(negedge clk);
        check(credit_a == ZP + 32'd100, "R5 capped", credit_a, ZP + 32'd100);
        @(negedge clk);
        check(credit_a == ZP + 32'd100, "R5 stays capped", credit_a, ZP + 32'd100);
        q_pend = 4'b0100;
        @(negedge clk);
        check(credit_a == ZP, "R8 positive reset when empty", credit_a, ZP);
        check(tx_active && tx_queue == 2'd2, "R3 frame not preempted", 32'(tx_queue), 32'd2);
        q_pend = 4'b0101;
        while (tx_active) @(negedge clk);
        wait_active(n);
        check(n == 1 && tx_queue == 2'd0, "R2 class A over q2", 32'(tx_queue), 32'd0);
    endtask

    task automatic t_stall();
        int n;
        bit quiet = 1'b1;
        do_reset();
        shaper_en = 1'b1; stall_sp_en = 1'b1;
        sr_ctrl_a = MODE | 32'd64; sr_hicred_a = ZP + 32'd1000;
        q_pend = 4'b0001;
        wait_active(n);
        measure(2'd0, 64, "R9 setup frame");
        q_pend = 4'b0101;
        repeat (20) begin @(negedge clk); if (tx_active) quiet = 1'b0; end
        check(quiet, "R9 q2 stalled behind class A", 32'(quiet), 32'd1);
        stall_sp_en = 1'b0;
        wait_active(n);
        check(n == 1 && tx_queue == 2'd2, "R9 q2 released", 32'(tx_queue), 32'd2);
    endtask

    task automatic t_mode0();
        int n;
        do_reset();
        shaper_en = 1'b1; sr_ctrl_a = 32'd64; sr_hicred_a = ZP + 32'd1000;
        q_pend = 4'b0001;
        wait_active(n);
        measure(2'd0, 64, "R10 mode0 frame");
        check(credit_a == ZP, "R10 mode0 credit zero", credit_a, ZP);
        wait_active(n);
        check(n == 1, "R10 mode0 regrant at once", 32'(n), 32'd1);
    endtask

    initial begin
        t_reset();
        t_strict();
        t_lengths();
        t_credit();
        t_cap();
        t_stall();
        t_mode0();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule